// File: doc/BRIEF.md
# Dual Programmable Tapped Delay Line

This block is a clocked model of a delay line with one input and two outputs. A single-bit input is shifted into a tap register on every clock. Each of the two outputs picks one tap and so plays the input waveform back after its own delay, counted in clock cycles. The delay is a fixed inherent part, `BASE_STEPS × STEP_CYC`, plus a 4-bit code times `STEP_CYC`. Rising and falling edges go through the same tap, so pulse width is kept.

Each output has its own 4-bit code input and enable. While the enable is high, the code register follows the code pins. While it is low, the last code is kept and pin activity is ignored. This lets both channels share one 8-bit bus, with each enable strobed in turn. Every code change that takes effect opens a settling window. During the window the channel's valid flag is low and its output holds the last value it showed. The window is longer when the change comes with a rising enable than when it is a pin change with the enable already high.

Top module: `dual_tap_delay`

## Requirements
- R1: While `rst` is high, both outputs are 0, both valid flags are 0 and both codes are 0. After `rst` falls, the valid flags rise on the `SETTLE_EN_CYC`-th clock edge.
- R2: With valid high, an input edge that is sampled on clock edge k appears at the output once edge k+d−1 has passed, where d = `BASE_STEPS*STEP_CYC + code*STEP_CYC`. The bench counts this as d edges from the clock after the input changes.
- R3: Code bits are binary with bit 0 as the LSB. Code 0000 gives the minimum delay `BASE_STEPS*STEP_CYC`. Code 1111 gives the maximum, `BASE_STEPS*STEP_CYC + 15*STEP_CYC`. The delay grows strictly with the code value.
- R4: A falling input edge is delayed by exactly as many cycles as a rising one, so the output pulse width equals the input pulse width.
- R5: The two channels are independent. A code change on one channel changes neither the delay nor the valid flag of the other.
- R6: With the enable already high on the previous edge, a new value on the code pins is taken on the next edge. The valid flag is low from that edge and returns high `SETTLE_PIN_CYC` edges later, which is `SETTLE_PIN_CYC+1` edges counted from the edge that samples the change.
- R7: While the enable is low, code pin changes are ignored. Valid stays high and the delay is unchanged.
- R8: A new code sampled on an edge where the enable is high after being low on the previous edge opens a window of `SETTLE_EN_CYC` edges. Valid returns high on the `SETTLE_EN_CYC+1`-th edge counted from the sampling edge. The code stays latched after the enable falls.
- R9: While valid is low, the output holds the value it had on the cycle before.
- R10: Presenting the code that is already held, with the enable high, opens no settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Line input |
| code_a | input | 4 | Delay code, channel A |
| en_a | input | 1 | Code enable, channel A (high = follow pins) |
| code_b | input | 4 | Delay code, channel B |
| en_b | input | 1 | Code enable, channel B (high = follow pins) |
| dout_a | output | 1 | Delayed output A |
| valid_a | output | 1 | Channel A delay settled |
| dout_b | output | 1 | Delayed output B |
| valid_b | output | 1 | Channel B delay settled |

## Verification
The assertions assume the following about the inputs:
- Reset is held for longer than one settling window, so the history that the window check looks back over starts inside reset.
- `SETTLE_EN_CYC` is at least `SETTLE_PIN_CYC`.

The stimulus keeps to these rules:
- Codes and enables change only at the falling clock edge.
- The input stays constant for a whole line depth before any delay is measured, so every measured edge is the only edge in the line.
- Pulses are longer than the largest delay.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    localparam int unsigned CODE_W = 4;
    localparam int unsigned NCODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t code;
        logic  en;
    } prog_t;

    typedef enum logic {
        SRC_ENABLE = 1'b0,
        SRC_PIN    = 1'b1
    } settle_src_e;

    function automatic int unsigned line_depth(input int unsigned base, input int unsigned step);
        return base + (NCODES - 1) * step;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tdl_shift.sv
module tdl_shift #(
    parameter int unsigned DEPTH = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst) taps[0] <= 1'b0;
        else     taps[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) taps[i] <= 1'b0;
            else     taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/tdl_prog.sv
module tdl_prog
    import tdl_pkg::*;
#(
    parameter int unsigned SETTLE_EN_CYC  = 15,
    parameter int unsigned SETTLE_PIN_CYC = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  prog_t prog,
    output code_t code_q,
    output logic  valid
);
    localparam int unsigned CW = width_for(SETTLE_EN_CYC > SETTLE_PIN_CYC ? SETTLE_EN_CYC : SETTLE_PIN_CYC);

    logic          en_d;
    logic [CW-1:0] cnt;
    logic          change;
    settle_src_e   src;

    assign change = prog.en && (prog.code != code_q);
    assign src    = en_d ? SRC_PIN : SRC_ENABLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d   <= 1'b0;
            code_q <= '0;
            cnt    <= CW'(SETTLE_EN_CYC);
        end else begin
            en_d <= prog.en;
            if (change) begin
                code_q <= prog.code;
                cnt    <= (src == SRC_PIN) ? CW'(SETTLE_PIN_CYC) : CW'(SETTLE_EN_CYC);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign valid = (cnt == '0);
endmodule

// File: rtl/tdl_tap.sv
module tdl_tap
    import tdl_pkg::*;
#(
    parameter int unsigned BASE  = 9,
    parameter int unsigned STEP  = 3,
    parameter int unsigned DEPTH = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] taps,
    input  code_t            code,
    input  logic             valid,
    output logic             dout
);
    localparam int unsigned IW = width_for(DEPTH);

    logic [IW-1:0] sel;
    logic          tap_val;
    logic          held_q;

    assign sel     = IW'(BASE - 1) + IW'(code) * IW'(STEP);
    assign tap_val = taps[sel];
    assign dout    = valid ? tap_val : held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= dout;
    end
endmodule

// File: rtl/dual_tap_delay.sv
module dual_tap_delay
    import tdl_pkg::*;
#(
    parameter int unsigned STEP_CYC       = 3,
    parameter int unsigned BASE_STEPS     = 3,
    parameter int unsigned SETTLE_EN_CYC  = 15,
    parameter int unsigned SETTLE_PIN_CYC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [3:0] code_a,
    input  logic       en_a,
    input  logic [3:0] code_b,
    input  logic       en_b,
    output logic       dout_a,
    output logic       valid_a,
    output logic       dout_b,
    output logic       valid_b
);
    localparam int unsigned BASE  = BASE_STEPS * STEP_CYC;
    localparam int unsigned DEPTH = line_depth(BASE, STEP_CYC);
    localparam int unsigned NCH   = 2;

    logic [DEPTH-1:0] taps;
    prog_t            prog  [NCH];
    code_t            code_q[NCH];
    logic             vld   [NCH];
    logic             dq    [NCH];

    assign prog[0] = '{code: code_a, en: en_a};
    assign prog[1] = '{code: code_b, en: en_b};

    tdl_shift #(.DEPTH(DEPTH)) i_line (
        .clk (clk),
        .rst (rst),
        .din (din),
        .taps(taps)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdl_prog #(
            .SETTLE_EN_CYC (SETTLE_EN_CYC),
            .SETTLE_PIN_CYC(SETTLE_PIN_CYC)
        ) i_prog (
            .clk   (clk),
            .rst   (rst),
            .prog  (prog[c]),
            .code_q(code_q[c]),
            .valid (vld[c])
        );

        tdl_tap #(
            .BASE (BASE),
            .STEP (STEP_CYC),
            .DEPTH(DEPTH)
        ) i_tap (
            .clk  (clk),
            .rst  (rst),
            .taps (taps),
            .code (code_q[c]),
            .valid(vld[c]),
            .dout (dq[c])
        );
    end

    assign dout_a  = dq[0];
    assign valid_a = vld[0];
    assign dout_b  = dq[1];
    assign valid_b = vld[1];
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
    parameter int unsigned SETTLE_PIN_CYC = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic [3:0] code_a,
    input logic       en_a,
    input logic [3:0] code_b,
    input logic       en_b,
    input logic       dout_a,
    input logic       valid_a,
    input logic       dout_b,
    input logic       valid_b
);
    // R1: reset quiets both channels
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!valid_a && !valid_b && !dout_a && !dout_b));

    // R9: output frozen while unsettled
    a_r9_hold_a: assert property (@(posedge clk) disable iff (rst)
        !valid_a |-> (dout_a == $past(dout_a)));

    a_r9_hold_b: assert property (@(posedge clk) disable iff (rst)
        !valid_b |-> (dout_b == $past(dout_b)));

    // R7: closed enable keeps a settled channel settled
    a_r7_lock_a: assert property (@(posedge clk) disable iff (rst)
        (valid_a && !en_a) |=> valid_a);

    a_r7_lock_b: assert property (@(posedge clk) disable iff (rst)
        (valid_b && !en_b) |=> valid_b);

    // R6: no window is shorter than the pin settling time
    a_r6_min_window_a: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_a) |-> $past(!valid_a, SETTLE_PIN_CYC));

    a_r6_min_window_b: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_b) |-> $past(!valid_b, SETTLE_PIN_CYC));
endmodule

bind dual_tap_delay tdl_checker #(.SETTLE_PIN_CYC(SETTLE_PIN_CYC)) i_tdl_checker (.*);

// File: tb/test_dual_tap_delay.sv
module test_dual_tap_delay;
    localparam time CLK_PERIOD = 10ns;
    localparam int  STEP  = 3;
    localparam int  BSTEP = 3;
    localparam int  SEN   = 15;
    localparam int  SPIN  = 10;
    localparam int  BASE  = BSTEP * STEP;
    localparam int  DEPTH = BASE + 15 * STEP;
    localparam int  NVEC  = 6;
    // upper nibble: code A, lower nibble: code B
    localparam logic [7:0] VEC [NVEC] = '{8'h0F, 8'hF0, 8'h12, 8'h48, 8'h79, 8'hA5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [3:0] code_a = '0, code_b = '0;
    logic en_a = 1'b1, en_b = 1'b1;
    logic dout_a, valid_a, dout_b, valid_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tap_delay #(
        .STEP_CYC(STEP), .BASE_STEPS(BSTEP),
        .SETTLE_EN_CYC(SEN), .SETTLE_PIN_CYC(SPIN)
    ) i_dual_tap_delay (
        .clk(clk), .rst(rst), .din(din),
        .code_a(code_a), .en_a(en_a), .code_b(code_b), .en_b(en_b),
        .dout_a(dout_a), .valid_a(valid_a), .dout_b(dout_b), .valid_b(valid_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int dly(input logic [3:0] c);
        return BASE + int'(c) * STEP;
    endfunction

    // drive din to lvl, count edges until each output shows it
    task automatic edge_delay(input logic lvl, output int da, output int db);
        din = lvl;
        da = -1;
        db = -1;
        for (int k = 1; k <= DEPTH + 5; k++) begin
            tick();
            if (da < 0 && dout_a == lvl) da = k;
            if (db < 0 && dout_b == lvl) db = k;
        end
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 40 && !(valid_a && valid_b); k++) tick();
    endtask

    initial begin
        int ra, rb, fa, fb, n;
        bit ok;
        @(negedge clk);
        for (int k = 0; k < 20; k++) tick();
        check(!valid_a && !valid_b && !dout_a && !dout_b, "R1 reset state", {valid_a, valid_b, dout_a, dout_b}, 0);
        rst = 1'b0;
        n = 0;
        for (int k = 0; k < 40 && !valid_a; k++) begin tick(); n++; end
        check(n == SEN, "R1 window after reset", n, SEN);

        // table of code pairs
        for (int v = 0; v < NVEC; v++) begin
            code_a = VEC[v][7:4];
            code_b = VEC[v][3:0];
            tick();
            wait_valid();
            edge_delay(1'b1, ra, rb);
            check(ra == dly(VEC[v][7:4]), "R2 R3 rise delay A", ra, dly(VEC[v][7:4]));
            check(rb == dly(VEC[v][3:0]), "R2 R3 rise delay B", rb, dly(VEC[v][3:0]));
            edge_delay(1'b0, fa, fb);
            check(fa == ra, "R4 fall delay A", fa, ra);
            check(fb == rb, "R4 fall delay B", fb, rb);
        end

        // R7: closed enables ignore pins (codes held at A=10, B=5)
        en_a = 1'b0;
        en_b = 1'b0;
        code_a = 4'd3;
        code_b = 4'd12;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin tick(); if (!(valid_a && valid_b)) ok = 1'b0; end
        check(ok, "R7 valid stays high", ok, 1);
        edge_delay(1'b1, ra, rb);
        check(ra == dly(4'd10), "R7 delay A unchanged", ra, dly(4'd10));
        check(rb == dly(4'd5), "R7 delay B unchanged", rb, dly(4'd5));
        edge_delay(1'b0, fa, fb);

        // R8: enable strobe on A latches code 3 with the long window
        en_a = 1'b1;
        n = 0;
        ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (k == 0) en_a = 1'b0;
            n++;
            if (!valid_b) ok = 1'b0;
            if (valid_a) break;
        end
        check(n == SEN + 1, "R8 enable window A", n, SEN + 1);
        check(ok, "R5 B valid untouched", ok, 1);
        edge_delay(1'b1, ra, rb);
        check(ra == dly(4'd3), "R8 latched delay A", ra, dly(4'd3));
        check(rb == dly(4'd5), "R5 delay B unchanged", rb, dly(4'd5));
        edge_delay(1'b0, fa, fb);

        // R10: reopening enable with same code
        en_a = 1'b1;
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin tick(); if (!valid_a) ok = 1'b0; end
        check(ok, "R10 same code no window", ok, 1);

        // R6: pin change with enable held high
        code_a = 4'd6;
        n = 0;
        for (int k = 0; k < 40; k++) begin tick(); n++; if (valid_a) break; end
        check(n == SPIN + 1, "R6 pin window A", n, SPIN + 1);
        edge_delay(1'b1, ra, rb);
        check(ra == dly(4'd6), "R6 new delay A", ra, dly(4'd6));

        // R9: output holds 1 through a window while input drops
        din = 1'b0;
        code_a = 4'd0;
        ok = 1'b1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (valid_a) break;
            n++;
            if (dout_a !== 1'b1) ok = 1'b0;
        end
        check(ok && n == SPIN, "R9 held output", n, SPIN);
        check(dout_a == 1'b0, "R9 new tap after window", dout_a, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule